// File: doc/BRIEF.md
# Circular Hardware Return Stack

This block keeps the return addresses for subroutine calls and interrupt entries in a small private store. It sits outside program and data memory. A call, or an interrupt that redirects the program counter, pushes the current 13-bit return address. A return-class instruction pops it back. The most recent entry is always shown on the output, so the program counter can take it in the same cycle as the pop request.

The stack pointer is internal, and software can neither read nor write it. The pointer is a counter that wraps in both directions, and nothing detects overflow or underflow. With a depth of 8, the ninth push writes over the entry from the first push, the tenth over the second, and so on. A pop from an empty stack returns whichever slot the wrapped pointer selects. The block has no path to the page-select latch used for jumps, so pushes and pops leave it unchanged.

The reset input is asserted asynchronously and released through a two-stage synchronizer. The pointer leaves reset on the second rising clock edge after `rst_n` goes high. Reset clears only the pointer and leaves the stored addresses as they were.

Top module: `return_stack`

## Requirements
- R1: A push request writes `push_addr_i` into the slot at the pointer and advances the pointer by one. From the next cycle, `top_addr_o` shows the pushed address.
- R2: `top_addr_o` always shows the slot just below the pointer. A pop without a push presents that value in the same cycle and moves the pointer back by one, so that the entry beneath it appears from the next cycle.
- R3: Up to 8 pushes followed by pops return the addresses in last-in, first-out order.
- R4: The pointer steps from slot 7 to slot 0 on a push. After more than 8 pushes, the newest push has overwritten the oldest surviving entry, and pops repeat the ring of the last 8 addresses.
- R5: A pop when the pointer is at slot 0 moves it to slot 7 and returns the content of slot 7. No error is raised.
- R6: When push and pop are both requested in one cycle, only the push takes effect and the pop is ignored. In the next cycle `top_addr_o` shows the pushed address.
- R7: Reset puts the pointer at slot 0 and keeps the stored addresses. The first push after reset lands in slot 0, and a second pop after that push returns the old content of slot 7.
- R8: In a cycle with neither request, the pointer and the stored entries stay unchanged, and `top_addr_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| push_i | input | 1 | Push request (call or interrupt entry) |
| push_addr_i | input | 13 | Return address to store on a push |
| pop_i | input | 1 | Pop request (return-class instruction) |
| top_addr_o | output | 13 | Most recent entry; the address popped when a pop is requested |

## Verification
A plain fill-then-drain run of 8 distinct addresses shows last-in, first-out order and separates a working stack from one with a wrong read offset. Draining past empty and pushing ten values in a row exercise the wrap in both directions, which is where a saturating or misdirected pointer would give different data. Cycles with both requests show push priority, idle cycles show that the state holds, and a reset taken partway through a sequence, followed by a push and two pops, shows that the pointer returns to slot 0 while the stored data survives.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  localparam int unsigned ADDR_W = 13;
  localparam int unsigned DEPTH  = 8;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/rstk_rst_sync.sv
module rstk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rstk_ptr.sv
module rstk_ptr
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH_P = DEPTH,
  localparam int unsigned PTR_W  = (DEPTH_P > 1) ? $clog2(DEPTH_P) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH_P - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic [PTR_W-1:0] ptr_up;
  logic [PTR_W-1:0] ptr_dn;
  logic             ptr_en;

  always_comb begin
    ptr_up = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
    ptr_dn = (ptr_q == '0) ? LAST : ptr_q - PTR_W'(1);
    ptr_en = 1'b0;
    ptr_d  = ptr_q;
    unique case (op)
      OP_PUSH: begin ptr_en = 1'b1; ptr_d = ptr_up; end
      OP_POP:  begin ptr_en = 1'b1; ptr_d = ptr_dn; end
      default: begin ptr_en = 1'b0; ptr_d = ptr_q;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign wr_idx = ptr_q;
  assign rd_idx = ptr_dn;

  // R1: a push advances the pointer by one slot
  p_push_adv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && wr_idx != LAST) |=> wr_idx == $past(wr_idx) + PTR_W'(1));
  // R2: a lone pop moves the pointer back by one slot
  p_pop_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && wr_idx != '0) |=> wr_idx == $past(wr_idx) - PTR_W'(1));
  // R4: upward wrap from the last slot
  p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && wr_idx == LAST) |=> wr_idx == '0);
  // R5: downward wrap from slot 0
  p_wrap_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && wr_idx == '0) |=> wr_idx == LAST);
  // R8: idle holds the pointer
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE) |=> $stable(wr_idx));
endmodule

// File: rtl/rstk_store.sv
module rstk_store
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH_P = DEPTH,
  parameter int unsigned WIDTH_P = ADDR_W,
  localparam int unsigned IDX_W  = (DEPTH_P > 1) ? $clog2(DEPTH_P) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [WIDTH_P-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [WIDTH_P-1:0] rd_data
);
  logic [WIDTH_P-1:0] slot_q [DEPTH_P];
  logic [DEPTH_P-1:0] slot_we;

  for (genvar g = 0; g < DEPTH_P; g++) begin : g_slot
    always_comb begin
      slot_we[g] = wr_en && (wr_idx == IDX_W'(g));
    end
    always_ff @(posedge clk) begin
      if (slot_we[g]) slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];

  // R1: the written word lands in the addressed slot
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> slot_q[$past(wr_idx)] == $past(wr_data));
  // R8: at most one slot is written per cycle
  p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we));
endmodule

// File: rtl/return_stack.sv
module return_stack
  import rstk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] top_addr_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             rst_sync_n;
  stk_op_e          op;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;

  rstk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // push wins over pop when both arrive together
  always_comb begin
    if (push_i)     op = OP_PUSH;
    else if (pop_i) op = OP_POP;
    else            op = OP_IDLE;
  end

  rstk_ptr #(.DEPTH_P(DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .op     (op),
    .wr_idx (wr_idx),
    .rd_idx (rd_idx)
  );

  rstk_store #(.DEPTH_P(DEPTH), .WIDTH_P(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (op == OP_PUSH),
    .wr_idx  (wr_idx),
    .wr_data (push_addr_i),
    .rd_idx  (rd_idx),
    .rd_data (top_addr_o)
  );

  // R1: a pushed address is on top in the next cycle
  p_push_on_top_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    push_i |=> top_addr_o == $past(push_addr_i));
  // R6: a pop arriving with a push is ignored
  p_push_wins_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (push_i && pop_i) |=> (top_addr_o == $past(push_addr_i)));
  // R8: nothing moves on an idle cycle
  p_idle_top_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!push_i && !pop_i) |=> $stable(top_addr_o));
endmodule

// File: tb/sim_return_stack.sv
module sim_return_stack;
  localparam time CLK_PERIOD = 10ns;
  localparam int  AW = 13;
  localparam int  DP = 8;

  typedef struct {
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_i = 1'b0;
  logic [AW-1:0] push_addr_i = '0;
  logic          pop_i = 1'b0;
  logic [AW-1:0] top_addr_o;
  logic          peek = 1'b0;

  int tests_run = 0;
  int tests_failed = 0;
  exp_t exp_q[$];

  logic [AW-1:0] model [DP];
  int            mp = 0;

  return_stack u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .push_addr_i (push_addr_i),
    .pop_i       (pop_i),
    .top_addr_o  (top_addr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // driver: one cycle of stimulus, expected values queued from the model
  task automatic step(input logic ps, input logic pp, input logic [AW-1:0] a,
                      input logic pk, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    push_i = ps; pop_i = pp; push_addr_i = a; peek = pk;
    if (pk) begin
      e.addr = model[(mp + DP - 1) % DP]; e.tag = tag; exp_q.push_back(e);
    end
    if (ps) begin
      model[mp] = a; mp = (mp + 1) % DP;
    end else if (pp) begin
      mp = (mp + DP - 1) % DP;
      if (!pk) begin
        e.addr = model[mp]; e.tag = tag; exp_q.push_back(e);
      end
    end
  endtask

  task automatic do_reset();
    @(posedge clk);
    #1;
    push_i = 0; pop_i = 0; peek = 0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    mp = 0;
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (rst_n && ((pop_i && !push_i) || peek)) begin
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        tests_run++;
        if (top_addr_o !== e.addr) begin
          tests_failed++;
          $display("FAIL %s: top_addr_o=%h expected %h", e.tag, top_addr_o, e.addr);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    tests_failed++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    do_reset();
    // R1: push then look at the top
    step(1, 0, 13'h0A5, 0, "");
    step(0, 0, 13'h000, 1, "R1");
    step(0, 1, 13'h000, 0, "R2");
    // R3: fill 8 then drain
    for (int i = 0; i < DP; i++) step(1, 0, AW'(13'h100 + i * 13'h111), 0, "");
    for (int i = 0; i < DP; i++) step(0, 1, 13'h000, 0, "R3");
    // R5: pop past empty wraps to slot 7
    step(0, 1, 13'h000, 0, "R5");
    step(0, 1, 13'h000, 0, "R5");
    // R4: ten pushes in a row, then drain a full ring and more
    for (int i = 0; i < 10; i++) step(1, 0, AW'(13'h1A00 + i * 13'h013), 0, "");
    for (int i = 0; i < 10; i++) step(0, 1, 13'h000, 0, "R4");
    // R6: push and pop together
    step(1, 1, 13'h0777, 0, "");
    step(0, 0, 13'h000, 1, "R6");
    step(1, 1, 13'h1234, 0, "");
    step(0, 1, 13'h000, 0, "R6");
    step(0, 1, 13'h000, 0, "R6");
    // R8: idle cycles hold the top
    step(1, 0, 13'h0ABC, 0, "");
    step(0, 0, 13'h000, 1, "R8");
    step(0, 0, 13'h1FFF, 1, "R8");
    step(0, 0, 13'h000, 1, "R8");
    step(0, 1, 13'h000, 0, "R8");
    // R7: reset partway, storage survives, pointer to slot 0
    for (int i = 0; i < DP; i++) step(1, 0, AW'(13'h0800 + i * 13'h021), 0, "");
    step(1, 0, 13'h0F0F, 0, "");
    step(1, 0, 13'h00F0, 0, "");
    do_reset();
    step(1, 0, 13'h1357, 0, "");
    step(0, 1, 13'h000, 0, "R7");
    step(0, 1, 13'h000, 0, "R7");
    step(0, 0, 13'h000, 0, "");
    step(0, 0, 13'h000, 0, "");
    if (exp_q.size() != 0) begin
      tests_failed++;
      $display("FAIL R2: %0d expected results unobserved, expected 0", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule